// File: doc/BRIEF.md
# Dual-Source UART Bit-Rate Engine

This block is a full-duplex asynchronous serial port whose bit clock comes from one of two sources. It has one buffer address. A write loads the transmitter and starts a frame. The read data port always shows the last byte the receiver completed. Both directions can run at the same time. Bytes travel least significant bit first.

The source select input chooses the bit-rate source:
- **Timer overflow path.** The divider reloads from an 8-bit timer value and applies a total division of 384.
- **Internal path.** The divider reloads from a 10-bit value, built from a low byte and a 2-bit high field, and applies a total division of 64.

A doubling input halves the period on either path. Each frame can be configured for an optional parity bit, with even or odd sense, and for one or two stop bits.

The receiver oversamples at 16 times the bit rate. It takes a majority vote over three samples around the middle of each bit. It drops any start that is not still low at mid-bit. Each direction has a done flag, and the receiver has a parity-error flag. Software clears the done flags through a two-bit clear strobe.

Top module: `uart_dual_baud`

## Requirements
- R1: After reset: txd is 1, tx_busy is 0, tx_done, rx_done and rx_par_err are 0, and bus_rdata is 0.
- R2: A bus_wr while tx_busy is 0 starts a frame on txd: a 0 start bit, then the 8 bits of bus_wdata least significant bit first, then the optional parity bit, then stop bits at 1.
- R3: With cfg_src_int = 0, one bit lasts 384 × (256 − tmr_reload) / 2^cfg_dbl clock cycles.
- R4: With cfg_src_int = 1, one bit lasts 64 × (1024 − REL) / 2^cfg_dbl clock cycles, where REL = {rel_hi, rel_lo}.
- R5: With cfg_par_en = 1, a parity bit follows the data. With cfg_par_odd = 0 it makes the count of ones in data plus parity even; with cfg_par_odd = 1 it makes that count odd.
- R6: With cfg_two_stop = 1, tx_busy stays 1 through a second stop bit. With cfg_two_stop = 0, tx_busy returns to 0 after one stop bit.
- R7: A bus_wr while tx_busy is 1 is ignored: the frame in flight is unchanged and no further frame follows.
- R8: The receiver decides each bit by a majority of three samples at ticks 7, 8 and 9 of the 16 ticks in a bit. It assembles the byte least significant bit first, places it on bus_rdata and sets rx_done during the first stop bit.
- R9: A low pulse on rxd that has ended by mid-bit does not produce a byte: rx_done stays 0 and bus_rdata keeps its value.
- R10: rx_par_err is loaded at the end of every frame: 1 if parity is enabled and the received parity bit is wrong, else 0.
- R11: tx_done is set when the first stop bit begins. flag_clr[0] clears rx_done and flag_clr[1] clears tx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_int | input | 1 | 0: timer-overflow source, 1: internal 10-bit reload source |
| cfg_dbl | input | 1 | Doubles the bit rate |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_odd | input | 1 | Parity sense, 1 = odd |
| cfg_two_stop | input | 1 | Two stop bits on transmit |
| tmr_reload | input | 8 | Timer reload byte |
| rel_lo | input | 8 | Internal reload, low byte |
| rel_hi | input | 2 | Internal reload, top bits |
| bus_wr | input | 1 | Write strobe to the buffer address |
| bus_wdata | input | 8 | Byte to transmit |
| bus_rdata | output | 8 | Receive holding register |
| flag_clr | input | 2 | [0] clears rx_done, [1] clears tx_done |
| tx_busy | output | 1 | Transmit frame pending or in flight |
| tx_done | output | 1 | Transmit done flag |
| rx_done | output | 1 | Receive done flag |
| rx_par_err | output | 1 | Parity error of the last received frame |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The bench measures the exact width of a start bit on both sources, with and without doubling, and with a reload value that uses the high bits. A wrong prescale factor or a dropped high field would show up as a start bit of the wrong length. It samples each transmitted bit at mid-bit, so a reversed bit order, an inverted parity sense or a missing second stop bit is caught on the line itself. A write that arrives while a frame is in flight must leave both the received byte and the idle line untouched; a design that restarted or queued the write would deliver the wrong byte or start an extra frame. A short glitch on rxd must be rejected. A frame with deliberately wrong parity must raise the error flag, and the next clean frame must drop it again.

// File: rtl/uart_pkg.sv
package uart_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_START = 3'd1,
      S_DATA  = 3'd2,
      S_PAR   = 3'd3,
      S_STOP1 = 3'd4,
      S_STOP2 = 3'd5
   } frm_st_t;

   function automatic logic maj3(input logic [2:0] v);
      return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
   endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
   parameter int TMRW    = 8,
   parameter int RELW    = 10,
   parameter int OVS     = 16,
   parameter int DIV_TMR = 384,
   parameter int DIV_INT = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            src_int,
   input  logic            dbl,
   input  logic [TMRW-1:0] tmr_reload,
   input  logic [RELW-1:0] rel_val,
   output logic            tick
);
   localparam int PRE_T = DIV_TMR / OVS;
   localparam int PRE_I = DIV_INT / OVS;
   localparam int PW    = $clog2(PRE_T + 1);
   localparam logic [PW-1:0] PD_T  = PW'(PRE_T);
   localparam logic [PW-1:0] PD_TD = PW'(PRE_T / 2);
   localparam logic [PW-1:0] PD_I  = PW'(PRE_I);
   localparam logic [PW-1:0] PD_ID = PW'(PRE_I / 2);

   generate
      if (RELW <= TMRW) begin : g_bad_width
         $error("reload counter must be wider than the timer byte");
      end
      if ((PRE_T % 2) != 0 || (PRE_I % 2) != 0 || PRE_I < 2) begin : g_bad_div
         $error("prescale factors must be even multiples of the oversampling rate");
      end
   endgenerate

   logic [RELW-1:0] cnt, load;
   logic [PW-1:0]   pcnt, pdiv;
   logic            ovf;

   // the timer reload is placed at the top of the wide counter so both
   // sources share one incrementer; period = 2^RELW - load
   assign load = src_int ? rel_val : {{(RELW-TMRW){1'b1}}, tmr_reload};
   assign ovf  = &cnt;
   assign pdiv = src_int ? (dbl ? PD_ID : PD_I) : (dbl ? PD_TD : PD_T);
   assign tick = ovf && (pcnt >= pdiv - PW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '1;
         pcnt <= '0;
      end else begin
         cnt <= ovf ? load : cnt + RELW'(1);
         if (ovf) pcnt <= tick ? '0 : pcnt + PW'(1);
      end
   end

   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt == $past(load)));
endmodule

// File: rtl/uart_tx_frm.sv
module uart_tx_frm
   import uart_pkg::*;
#(
   parameter int DW  = 8,
   parameter int OVS = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          par_en,
   input  logic          par_odd,
   input  logic          two_stop,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          clr_done,
   output logic          txd,
   output logic          busy,
   output logic          done
);
   localparam int SW = $clog2(OVS);
   localparam int BW = $clog2(DW);
   localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

   frm_st_t       st;
   logic          pend, par_q;
   logic [DW-1:0] sh;
   logic [BW-1:0] bitn;
   logic [SW-1:0] sub;

   assign busy = pend || (st != S_IDLE);

   always_comb begin
      case (st)
         S_START: txd = 1'b0;
         S_DATA:  txd = sh[0];
         S_PAR:   txd = par_q;
         default: txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         pend  <= 1'b0;
         par_q <= 1'b0;
         sh    <= '0;
         bitn  <= '0;
         sub   <= '0;
         done  <= 1'b0;
      end else begin
         if (clr_done) done <= 1'b0;
         if (st == S_IDLE) begin
            if (pend && tick) begin
               st   <= S_START;
               pend <= 1'b0;
               sub  <= '0;
            end else if (wr && !pend) begin
               pend  <= 1'b1;
               sh    <= wdata;
               par_q <= (^wdata) ^ par_odd;
            end
         end else if (tick) begin
            sub <= sub + SW'(1);
            if (sub == SUB_LAST) begin
               case (st)
                  S_START: begin
                     st   <= S_DATA;
                     bitn <= '0;
                  end
                  S_DATA: begin
                     sh   <= sh >> 1;
                     bitn <= bitn + BW'(1);
                     if (bitn == BIT_LAST) begin
                        if (par_en) st <= S_PAR;
                        else begin
                           st   <= S_STOP1;
                           done <= 1'b1;
                        end
                     end
                  end
                  S_PAR: begin
                     st   <= S_STOP1;
                     done <= 1'b1;
                  end
                  S_STOP1: st <= two_stop ? S_STOP2 : S_IDLE;
                  default: st <= S_IDLE;
               endcase
            end
         end
      end
   end

   a_r1_mark_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);
   a_r2_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr));
   a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr) |=> $stable(par_q));
   a_r11_done_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (st == S_STOP1));
endmodule

// File: rtl/uart_rx_frm.sv
module uart_rx_frm
   import uart_pkg::*;
#(
   parameter int DW  = 8,
   parameter int OVS = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          rxd,
   input  logic          par_en,
   input  logic          par_odd,
   input  logic          clr_done,
   output logic [DW-1:0] rdata,
   output logic          done,
   output logic          par_err
);
   localparam int SW = $clog2(OVS);
   localparam int BW = $clog2(DW);
   localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
   localparam logic [SW-1:0] SMP_LO   = SW'(OVS/2 - 1);
   localparam logic [SW-1:0] SMP_HI   = SW'(OVS/2 + 1);
   localparam logic [SW-1:0] FIN_AT   = SW'(OVS/2 + 2);
   localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

   frm_st_t       st;
   logic [1:0]    sync;
   logic          rx_s, bitv, pbit;
   logic [2:0]    votes;
   logic [DW-1:0] sh;
   logic [BW-1:0] bitn;
   logic [SW-1:0] sub;

   assign rx_s = sync[1];
   assign bitv = maj3(votes);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync    <= 2'b11;
         st      <= S_IDLE;
         votes   <= 3'b111;
         sh      <= '0;
         bitn    <= '0;
         sub     <= '0;
         pbit    <= 1'b0;
         rdata   <= '0;
         done    <= 1'b0;
         par_err <= 1'b0;
      end else begin
         sync <= {sync[0], rxd};
         if (clr_done) done <= 1'b0;
         if (st == S_IDLE) begin
            if (tick && !rx_s) begin
               st  <= S_START;
               sub <= '0;
            end
         end else if (tick) begin
            sub <= sub + SW'(1);
            if (sub >= SMP_LO && sub <= SMP_HI) votes <= {votes[1:0], rx_s};
            if (st == S_STOP1 && sub == FIN_AT) begin
               rdata   <= sh;
               done    <= 1'b1;
               par_err <= par_en && (pbit != ((^sh) ^ par_odd));
               st      <= S_IDLE;
            end else if (sub == SUB_LAST) begin
               case (st)
                  S_START: begin
                     st   <= bitv ? S_IDLE : S_DATA;
                     bitn <= '0;
                  end
                  S_DATA: begin
                     sh   <= {bitv, sh[DW-1:1]};
                     bitn <= bitn + BW'(1);
                     if (bitn == BIT_LAST) st <= par_en ? S_PAR : S_STOP1;
                  end
                  S_PAR: begin
                     pbit <= bitv;
                     st   <= S_STOP1;
                  end
                  default: st <= S_IDLE;
               endcase
            end
         end
      end
   end

   a_r8_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(st) == S_STOP1));
   a_r9_start_low_at_mid: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(st) == S_START) && (st == S_DATA)) |-> ($countones($past(votes)) < 2));
   a_r10_err_needs_parity: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_err) |-> $past(par_en));
endmodule

// File: rtl/uart_dual_baud.sv
module uart_dual_baud #(
   parameter int DW   = 8,
   parameter int TMRW = 8,
   parameter int RELW = 10,
   parameter int OVS  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_src_int,
   input  logic                 cfg_dbl,
   input  logic                 cfg_par_en,
   input  logic                 cfg_par_odd,
   input  logic                 cfg_two_stop,
   input  logic [TMRW-1:0]      tmr_reload,
   input  logic [DW-1:0]        rel_lo,
   input  logic [RELW-DW-1:0]   rel_hi,
   input  logic                 bus_wr,
   input  logic [DW-1:0]        bus_wdata,
   output logic [DW-1:0]        bus_rdata,
   input  logic [1:0]           flag_clr,
   output logic                 tx_busy,
   output logic                 tx_done,
   output logic                 rx_done,
   output logic                 rx_par_err,
   input  logic                 rxd,
   output logic                 txd
);
   generate
      if (RELW <= DW) begin : g_bad_rel
         $error("reload value must be wider than the low byte");
      end
      if ((OVS & (OVS - 1)) != 0 || OVS < 8) begin : g_bad_ovs
         $error("oversampling rate must be a power of two of at least 8");
      end
   endgenerate

   logic tick;

   uart_baud_gen #(.TMRW(TMRW), .RELW(RELW), .OVS(OVS)) u_baud (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_int    (cfg_src_int),
      .dbl        (cfg_dbl),
      .tmr_reload (tmr_reload),
      .rel_val    ({rel_hi, rel_lo}),
      .tick       (tick)
   );

   uart_tx_frm #(.DW(DW), .OVS(OVS)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .par_en   (cfg_par_en),
      .par_odd  (cfg_par_odd),
      .two_stop (cfg_two_stop),
      .wr       (bus_wr),
      .wdata    (bus_wdata),
      .clr_done (flag_clr[1]),
      .txd      (txd),
      .busy     (tx_busy),
      .done     (tx_done)
   );

   uart_rx_frm #(.DW(DW), .OVS(OVS)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .rxd      (rxd),
      .par_en   (cfg_par_en),
      .par_odd  (cfg_par_odd),
      .clr_done (flag_clr[0]),
      .rdata    (bus_rdata),
      .done     (rx_done),
      .par_err  (rx_par_err)
   );
endmodule

// File: tb/sim_uart_dual_baud.sv
`timescale 1ns/1ps
module sim_uart_dual_baud;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_src_int = 1'b0, cfg_dbl = 1'b0, cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
   logic [7:0] tmr_reload = 8'hFF, rel_lo = 8'hFF, bus_wdata = 8'h00;
   logic [1:0] rel_hi = 2'b11, flag_clr = 2'b00;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_rdata;
   logic       tx_busy, tx_done, rx_done, rx_par_err, txd, rxd;
   logic       loop_en = 1'b1, drv_rxd = 1'b1;
   int         n_chk = 0, n_bad = 0;
   bit         fin = 1'b0;

   always #2.5 clk = ~clk;
   assign rxd = loop_en ? txd : drv_rxd;

   uart_dual_baud u0 (
      .clk(clk), .rst_n(rst_n), .cfg_src_int(cfg_src_int), .cfg_dbl(cfg_dbl),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
      .tmr_reload(tmr_reload), .rel_lo(rel_lo), .rel_hi(rel_hi), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_clr(flag_clr),
      .tx_busy(tx_busy), .tx_done(tx_done), .rx_done(rx_done), .rx_par_err(rx_par_err),
      .rxd(rxd), .txd(txd)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int bit_clks(input bit src, input bit dbl, input int th1, input int rel);
      int pre = src ? 64 : 384;
      int per = src ? (1024 - rel) : (256 - th1);
      return (pre * per) >> dbl;
   endfunction

   function automatic bit exp_par(input logic [7:0] d, input bit odd);
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(d[i]);
      return ((ones % 2) == 1) ^ odd;
   endfunction

   task automatic set_cfg(input bit src, input bit dbl, input int th1, input int rel,
                          input bit pen, input bit podd, input bit two);
      @(negedge clk);
      cfg_src_int = src; cfg_dbl = dbl; cfg_par_en = pen;
      cfg_par_odd = podd; cfg_two_stop = two;
      tmr_reload = 8'(th1); rel_lo = rel[7:0]; rel_hi = rel[9:8];
   endtask

   task automatic clear_flags();
      @(negedge clk) flag_clr = 2'b11;
      @(negedge clk) flag_clr = 2'b00;
      chk(!rx_done && !tx_done, "R11 flags cleared", {rx_done, tx_done}, 0);
   endtask

   task automatic wait_rx(input int lim, input logic [7:0] d, input bit perr);
      int t = 0;
      while (!rx_done && t < lim) begin @(negedge clk); t++; end
      chk(rx_done == 1'b1, "R8 rx_done set", rx_done, 1);
      chk(bus_rdata == d, "R8 received byte", bus_rdata, d);
      chk(rx_par_err == perr, "R10 parity error flag", rx_par_err, perr);
   endtask

   // one loopback frame; measure: check start-bit width only (needs d[0]=1)
   task automatic frame(input logic [7:0] d, input bit src, input bit dbl, input int th1,
                        input int rel, input bit pen, input bit podd, input bit two,
                        input bit extra, input bit measure);
      int b = bit_clks(src, dbl, th1, rel);
      int w = 0;
      logic [7:0] got = 8'h00;
      while (tx_busy) @(negedge clk);
      set_cfg(src, dbl, th1, rel, pen, podd, two);
      loop_en = 1'b1;
      @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
      while (txd !== 1'b0) @(negedge clk);
      if (measure) begin
         while (txd == 1'b0) begin w++; @(negedge clk); end
         chk(w == b, src ? "R4 bit period" : "R3 bit period", w, b);
         wait_rx(14 * b, d, 1'b0);
      end else begin
         repeat (b / 2) @(negedge clk);
         chk(txd == 1'b0, "R2 start bit", txd, 0);
         for (int i = 0; i < 8; i++) begin
            if (extra && i == 4) begin
               bus_wr = 1'b1; bus_wdata = ~d;
               @(negedge clk); bus_wr = 1'b0;
               repeat (b - 1) @(negedge clk);
            end else begin
               repeat (b) @(negedge clk);
            end
            got[i] = txd;
            if (i == 7) chk(tx_done == 1'b0, "R11 tx_done low before stop", tx_done, 0);
         end
         chk(got == d, "R2 data LSB first", got, d);
         if (pen) begin
            repeat (b) @(negedge clk);
            chk(txd == exp_par(d, podd), "R5 parity bit", txd, exp_par(d, podd));
         end
         repeat (b) @(negedge clk);
         chk(txd == 1'b1, "R2 stop bit", txd, 1);
         chk(tx_done == 1'b1, "R11 tx_done at stop", tx_done, 1);
         repeat (b) @(negedge clk);
         if (two) chk(tx_busy && txd, "R6 second stop bit", {tx_busy, txd}, 3);
         else     chk(!tx_busy, "R6 idle after one stop", tx_busy, 0);
         if (extra) begin
            repeat (2 * b) @(negedge clk);
            chk(!tx_busy && txd, "R7 no frame from busy write", {tx_busy, txd}, 1);
         end
         wait_rx(4 * b, d, 1'b0);
      end
      clear_flags();
   endtask

   task automatic drive_rx(input logic [7:0] d, input bit pen, input bit pbit, input int b);
      loop_en = 1'b0;
      @(negedge clk) drv_rxd = 1'b0;
      repeat (b) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         drv_rxd = d[i];
         repeat (b) @(negedge clk);
      end
      if (pen) begin
         drv_rxd = pbit;
         repeat (b) @(negedge clk);
      end
      drv_rxd = 1'b1;
      repeat (2 * b) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd idle", txd, 1);
      chk(!tx_busy && !tx_done, "R1 tx idle flags", {tx_busy, tx_done}, 0);
      chk(!rx_done && !rx_par_err, "R1 rx flags", {rx_done, rx_par_err}, 0);
      chk(bus_rdata == 8'h00, "R1 rdata", bus_rdata, 0);

      // R3 / R4 bit periods
      frame(8'h01, 0, 0, 255, 1023, 0, 0, 0, 0, 1);
      frame(8'h81, 0, 1, 254, 1023, 0, 0, 0, 0, 1);
      frame(8'h01, 1, 0, 255, 1023, 0, 0, 0, 0, 1);
      frame(8'h03, 1, 1, 255, 1021, 0, 0, 0, 0, 1);

      // R2 R5 R6 frame shapes
      frame(8'hA5, 1, 0, 255, 1023, 1, 0, 0, 0, 0);
      frame(8'h5B, 1, 1, 255, 1022, 1, 1, 1, 0, 0);
      frame(8'h70, 0, 1, 255, 1023, 0, 0, 1, 0, 0);

      // R7 write while busy
      frame(8'h3C, 1, 0, 255, 1023, 0, 0, 0, 1, 0);

      // R9 glitch on rxd is not a start
      set_cfg(1, 0, 255, 1023, 0, 0, 0);
      loop_en = 1'b0;
      @(negedge clk) drv_rxd = 1'b0;
      repeat (3) @(negedge clk);
      drv_rxd = 1'b1;
      repeat (20 * 64) @(negedge clk);
      chk(rx_done == 1'b0, "R9 glitch rejected", rx_done, 0);
      chk(bus_rdata == 8'h3C, "R9 holding register kept", bus_rdata, 8'h3C);

      // R10 parity error latched per frame
      set_cfg(1, 0, 255, 1023, 1, 0, 0);
      drive_rx(8'h5A, 1, ~exp_par(8'h5A, 0), 64);
      wait_rx(64, 8'h5A, 1'b1);
      clear_flags();
      drive_rx(8'h96, 1, exp_par(8'h96, 0), 64);
      wait_rx(64, 8'h96, 1'b0);
      clear_flags();
      set_cfg(1, 0, 255, 1023, 1, 1, 0);
      drive_rx(8'h0F, 1, ~exp_par(8'h0F, 1), 64);
      wait_rx(64, 8'h0F, 1'b1);
      clear_flags();

      // constrained random loopback frames
      seed = 1357;
      void'($urandom(seed));
      for (int k = 0; k < 6; k++) begin
         bit src = 1'($urandom);
         frame(8'($urandom), src, 1'($urandom), 254 + int'($urandom % 2),
               1021 + int'($urandom % 3), 1'($urandom), 1'($urandom),
               1'($urandom), 1'b0, 1'b0);
      end

      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule